// File: doc/BRIEF.md
# Slave-Serial Configuration Sequencer

This block loads a programmable device over a slave-serial link. On a start strobe it pulls the device's active-low program line low for a fixed number of system clock cycles, then releases it. Next it polls the device's init-ready pin until the pin is high, and then shifts a requested number of configuration bytes out on a data line and a serial clock line. After the last byte it keeps pulsing the serial clock until the device raises its done pin. Both waits have a bound, and reaching a bound ends the run with a timeout flag.

Bytes arrive on a valid/ready stream that carries an error flag. A byte that is offered with the error flag set is not shifted, and the block moves straight to the done phase. The init and done pins pass through two-flop synchronizers before they are sampled. The serial clock half-period, the program-low hold time and both poll limits are parameters counted in system clock cycles.

Top module: `slave_cfg_loader`

## Requirements
- R1: After reset, and whenever busy_o is low, program_n_o is 1, cclk_o is 0 and din_o is 0. After reset busy_o, success_o, timeout_o and data_ready_o are all 0.
- R2: A start strobe taken while idle drives program_n_o low for exactly PROG_LOW cycles, starting in the cycle after the strobe, and then drives it high. While program_n_o is low, busy_o is high.
- R3: After release, the synchronized init pin is sampled once per cycle for at most INIT_MAX polls. An init input that rises d cycles after release is first seen at poll d+3, so the run goes on if d <= INIT_MAX-3. If the limit is reached, timeout_o is set, busy_o falls after PROG_LOW+INIT_MAX busy cycles, and cclk_o never pulses.
- R4: Each byte is sent MSB first, one bit per cclk_o pulse. din_o is set before cclk_o rises and holds steady while cclk_o is high.
- R5: Exactly byte_count_i bytes are shifted (8 pulses each), and this does not depend on done. A count of 0 requests no byte and goes straight to the done phase.
- R6: A byte offered with data_valid_i and data_err_i both high is consumed but not shifted. No later byte is shifted, and the block enters the done phase.
- R7: In the done phase the synchronized done pin is checked before each extra pulse. When it is high, success_o is set and busy_o falls. The total number of cclk_o pulses is therefore max(8*shifted bytes, pulse index at which done rises).
- R8: If done is still low after DONE_MAX extra pulses, timeout_o is set and busy_o falls, for a total of 8*shifted bytes + DONE_MAX pulses.
- R9: busy_o is high from the cycle after the start strobe until the run ends. Of busy_o, success_o and timeout_o, at most one is high at a time. A status flag holds until the next start strobe clears it. A start strobe seen while busy_o is high, including the cycle in which the run ends, has no effect.
- R10: Every cclk_o high phase lasts exactly HALF cycles, and every low phase between pulses lasts at least HALF cycles.
- R11: data_ready_o is high only while the block waits for a byte, with cclk_o low. While data_valid_i stays low, no cclk_o pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| byte_count_i | input | CNT_W | Number of bytes to shift, latched at start |
| data_i | input | 8 | Configuration byte |
| data_valid_i | input | 1 | data_i (or an error) is offered |
| data_err_i | input | 1 | Stream error with the offered beat |
| data_ready_o | output | 1 | Block accepts a beat this cycle |
| init_i | input | 1 | Device init-ready pin (asynchronous) |
| done_i | input | 1 | Device done pin (asynchronous) |
| program_n_o | output | 1 | Active-low program line to the device |
| cclk_o | output | 1 | Serial configuration clock |
| din_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | A run is in progress |
| success_o | output | 1 | Last run ended with done high |
| timeout_o | output | 1 | Last run hit a poll limit |

## Verification
Two things can fall on the same check in the done phase: the done pin arriving, and the pulse limit being reached. The bench sweeps the pulse index at which its device model raises done across the whole window, past DONE_MAX. It expects success up to 8*bytes+DONE_MAX pulses and a timeout one beyond that, so the check order, done before limit, decides the boundary. The second overlap is a start strobe that is still high on the edge where the run ends. The strobe is held through completion, and the bench checks that busy_o stays low and the status holds afterwards.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PROG  = 3'd1,
        ST_INITW = 3'd2,
        ST_FETCH = 3'd3,
        ST_SHIFT = 3'd4,
        ST_POST  = 3'd5
    } cfgl_state_e;

endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Two-flop synchronizer for each bit.
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= d_i[g];
                s2_q <= s1_q;
            end
        end
        assign q_o[g] = s2_q;
    end
endmodule

// File: rtl/cfgl_shift.sv
module cfgl_shift
    import cfgl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic              clr_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              bit_o,
    output logic              last_o
);
    localparam int IW = $clog2(BYTE_W);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [IW-1:0]     idx;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.sh  = '0;
            d.idx = '0;
        end else if (load_i) begin
            d.sh  = data_i;
            d.idx = IW'(BYTE_W - 1);
        end else if (adv_i) begin
            d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
            d.idx = q.idx - IW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bit_o  = q.sh[BYTE_W-1];
    assign last_o = (q.idx == '0);

    // R4: the controller issues one operation per cycle
    p_single_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({load_i, adv_i, clr_i}) <= 1);

    // R5: never advance past the final bit of a byte
    p_adv_not_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> !last_o);
endmodule

// File: rtl/slave_cfg_loader.sv
module slave_cfg_loader
    import cfgl_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PROG_LOW = 64,
    parameter int HALF     = 3,
    parameter int INIT_MAX = 100000,
    parameter int DONE_MAX = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  byte_count_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              data_valid_i,
    input  logic              data_err_i,
    output logic              data_ready_o,
    input  logic              init_i,
    input  logic              done_i,
    output logic              program_n_o,
    output logic              cclk_o,
    output logic              din_o,
    output logic              busy_o,
    output logic              success_o,
    output logic              timeout_o
);
    localparam int MAXA = (PROG_LOW > INIT_MAX) ? PROG_LOW : INIT_MAX;
    localparam int MAXV = (MAXA > DONE_MAX) ? MAXA : DONE_MAX;
    localparam int CW   = $clog2(MAXV + 1);
    localparam int HW   = $clog2(HALF + 1);

    typedef struct packed {
        cfgl_state_e      st;
        logic [CW-1:0]    cnt;
        logic [HW-1:0]    hcnt;
        logic             ph;
        logic [CNT_W-1:0] left;
        logic             program_n;
        logic             cclk;
        logic             busy;
        logic             success;
        logic             timeout;
    } ctl_t;

    ctl_t q, d;

    logic [1:0] pins_s;
    logic       init_s, done_s;
    logic       sh_load, sh_adv, sh_clr;
    logic       sh_bit, sh_last;
    logic       half_end;

    cfgl_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({done_i, init_i}),
        .q_o   (pins_s)
    );
    assign init_s = pins_s[0];
    assign done_s = pins_s[1];

    cfgl_shift u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (sh_load),
        .adv_i  (sh_adv),
        .clr_i  (sh_clr),
        .data_i (data_i),
        .bit_o  (sh_bit),
        .last_o (sh_last)
    );

    assign half_end = (q.hcnt == HW'(HALF - 1));

    always_comb begin
        d       = q;
        sh_load = 1'b0;
        sh_adv  = 1'b0;
        sh_clr  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st        = ST_PROG;
                    d.cnt       = '0;
                    d.program_n = 1'b0;
                    d.cclk      = 1'b0;
                    d.busy      = 1'b1;
                    d.success   = 1'b0;
                    d.timeout   = 1'b0;
                    d.left      = byte_count_i;
                    sh_clr      = 1'b1;
                end
            end
            ST_PROG: begin
                if (q.cnt == CW'(PROG_LOW - 1)) begin
                    d.program_n = 1'b1;
                    d.cnt       = '0;
                    d.st        = ST_INITW;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            ST_INITW: begin
                if (init_s) begin
                    d.cnt  = '0;
                    d.hcnt = '0;
                    d.ph   = 1'b0;
                    d.st   = (q.left == '0) ? ST_POST : ST_FETCH;
                end else if (q.cnt == CW'(INIT_MAX - 1)) begin
                    d.timeout = 1'b1;
                    d.busy    = 1'b0;
                    d.st      = ST_IDLE;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            ST_FETCH: begin
                if (data_valid_i) begin
                    d.hcnt = '0;
                    d.ph   = 1'b0;
                    if (data_err_i) begin
                        d.cnt  = '0;
                        d.st   = ST_POST;
                        sh_clr = 1'b1;
                    end else begin
                        d.st    = ST_SHIFT;
                        sh_load = 1'b1;
                    end
                end
            end
            ST_SHIFT: begin
                if (!half_end) begin
                    d.hcnt = q.hcnt + HW'(1);
                end else begin
                    d.hcnt = '0;
                    if (!q.ph) begin
                        d.cclk = 1'b1;
                        d.ph   = 1'b1;
                    end else begin
                        d.cclk = 1'b0;
                        d.ph   = 1'b0;
                        if (!sh_last) begin
                            sh_adv = 1'b1;
                        end else if (q.left == CNT_W'(1)) begin
                            d.left = '0;
                            d.cnt  = '0;
                            d.st   = ST_POST;
                            sh_clr = 1'b1;
                        end else begin
                            d.left = q.left - CNT_W'(1);
                            d.st   = ST_FETCH;
                        end
                    end
                end
            end
            ST_POST: begin
                if (!half_end) begin
                    d.hcnt = q.hcnt + HW'(1);
                end else begin
                    d.hcnt = '0;
                    if (!q.ph) begin
                        if (done_s) begin
                            d.success = 1'b1;
                            d.busy    = 1'b0;
                            d.st      = ST_IDLE;
                        end else if (q.cnt == CW'(DONE_MAX)) begin
                            d.timeout = 1'b1;
                            d.busy    = 1'b0;
                            d.st      = ST_IDLE;
                        end else begin
                            d.cclk = 1'b1;
                            d.ph   = 1'b1;
                            d.cnt  = q.cnt + CW'(1);
                        end
                    end else begin
                        d.cclk = 1'b0;
                        d.ph   = 1'b0;
                    end
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.st        <= ST_IDLE;
            q.program_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign data_ready_o = (q.st == ST_FETCH);
    assign program_n_o  = q.program_n;
    assign cclk_o       = q.cclk;
    assign din_o        = sh_bit;
    assign busy_o       = q.busy;
    assign success_o    = q.success;
    assign timeout_o    = q.timeout;

    // R1: lines at rest whenever no run is active
    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (program_n_o && !cclk_o && !din_o));

    // R2: program pulse only inside a run
    p_prog_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !program_n_o |-> (busy_o && !cclk_o));

    // R4: data line steady while the serial clock is high
    p_din_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_o |-> $stable(din_o));

    // R9: busy and the two status flags are mutually exclusive
    p_status_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_o, success_o, timeout_o}));

    // R9: a status flag holds until a start strobe
    p_success_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (success_o && !start_i) |=> success_o);
    p_timeout_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && !start_i) |=> timeout_o);

    // R11: ready only while waiting for a byte with the clock low
    p_ready_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready_o |-> (busy_o && program_n_o && !cclk_o));
endmodule

// File: tb/slave_cfg_loader_tb.sv
module slave_cfg_loader_tb;
    localparam int PL   = 5;
    localparam int HALF = 2;
    localparam int IMAX = 30;
    localparam int DMAX = 10;
    localparam int CW   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          start_i = 1'b0;
    logic [CW-1:0] byte_count_i = '0;
    logic [7:0]    data_i = '0;
    logic          data_valid_i = 1'b0;
    logic          data_err_i = 1'b0;
    logic          init_i = 1'b1;
    logic          done_i = 1'b0;
    logic          data_ready_o, program_n_o, cclk_o, din_o;
    logic          busy_o, success_o, timeout_o;

    slave_cfg_loader #(
        .CNT_W(CW), .PROG_LOW(PL), .HALF(HALF), .INIT_MAX(IMAX), .DONE_MAX(DMAX)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_count_i(byte_count_i),
        .data_i(data_i), .data_valid_i(data_valid_i), .data_err_i(data_err_i),
        .data_ready_o(data_ready_o), .init_i(init_i), .done_i(done_i),
        .program_n_o(program_n_o), .cclk_o(cclk_o), .din_o(din_o),
        .busy_o(busy_o), .success_o(success_o), .timeout_o(timeout_o)
    );

    int checks = 0;
    int errors = 0;

    int cfg_seed = 0, cfg_idel = 0, cfg_dafter = 0, cfg_errat = -1, cfg_stall = 0;
    bit feed_en = 1'b0, run_act = 1'b0;
    int since_rel = 1 << 20;
    int rise_cnt = 0, feed_idx = 0, busy_cyc = 0, prog_cyc = 0, ready_seen = 0;
    int hi_run = 0, bad_hi = 0, cyc = 0;
    bit take_pend = 1'b0, prev_cclk = 1'b0;
    bit rx_bits [0:511];

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 73 + cfg_seed * 29 + 17) ^ (i << 3));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor, device model and byte source, all on the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (cclk_o && !prev_cclk) begin
            if (rise_cnt < 512) rx_bits[rise_cnt] = din_o;
            rise_cnt++;
            hi_run = 1;
        end else if (cclk_o) begin
            hi_run++;
        end
        if (!cclk_o && prev_cclk && hi_run != HALF) bad_hi++;
        prev_cclk = cclk_o;
        if (busy_o) busy_cyc++;
        if (!program_n_o) prog_cyc++;
        if (data_ready_o) ready_seen++;
        if (!program_n_o) begin
            since_rel = 0;
            init_i = 1'b0;
        end else begin
            if (since_rel < (1 << 20)) since_rel++;
            init_i = (since_rel > cfg_idel);
        end
        done_i = run_act && program_n_o && (rise_cnt >= cfg_dafter);
        if (take_pend) begin
            feed_idx++;
            take_pend = 1'b0;
        end
        data_i = pat(feed_idx);
        data_err_i = (feed_idx == cfg_errat);
        data_valid_i = feed_en && !(cfg_stall != 0 && (cyc % 3) != 0);
        if (data_ready_o && data_valid_i) take_pend = 1'b1;
    end

    // smode: 0 plain, 1 start pulse mid-run, 2 start held through completion
    task automatic run_seq(input int nb, input int seed, input int idel, input int dafter,
                           input int errat, input int stall, input int smode);
        int n;
        int shifted, sb, exp_rise, mism, k;
        bit init_ok, exp_succ;
        logic [7:0] b;
        cfg_seed = seed; cfg_idel = idel; cfg_dafter = dafter;
        cfg_errat = errat; cfg_stall = stall;
        @(negedge clk);
        rise_cnt = 0; feed_idx = 0; busy_cyc = 0; prog_cyc = 0; ready_seen = 0;
        bad_hi = 0; take_pend = 1'b0;
        feed_en = 1'b1; run_act = 1'b1;
        start_i = 1'b1;
        byte_count_i = CW'(nb);
        @(negedge clk);
        if (smode != 2) start_i = 1'b0;
        // R9: start clears status and raises busy
        chk(busy_o && !success_o && !timeout_o, "R9 start clears status", busy_o, 1);
        n = 0;
        while (busy_o && n < 5000) begin
            @(negedge clk);
            n++;
            if (smode == 1 && n == 40) start_i = 1'b1;
            if (smode == 1 && n == 41) start_i = 1'b0;
        end
        start_i = 1'b0;
        chk(n < 5000, "R9 run ends", n, 0);
        feed_en = 1'b0;
        shifted = (errat >= 0 && errat < nb) ? errat : nb;
        sb = shifted * 8;
        init_ok = (idel <= IMAX - 3);
        chk(prog_cyc == PL, "R2 program low cycles", prog_cyc, PL);
        if (!init_ok) begin
            chk(timeout_o && !success_o, "R3 init timeout", timeout_o, 1);
            chk(busy_cyc == PL + IMAX, "R3 busy cycles on init timeout", busy_cyc, PL + IMAX);
            chk(rise_cnt == 0, "R3 no clock on init timeout", rise_cnt, 0);
        end else begin
            exp_succ = (dafter <= sb + DMAX);
            exp_rise = exp_succ ? ((dafter > sb) ? dafter : sb) : sb + DMAX;
            if (exp_succ)
                chk(success_o && !timeout_o, "R7 success on done", success_o, 1);
            else
                chk(timeout_o && !success_o, "R8 done timeout", timeout_o, 1);
            chk(rise_cnt == exp_rise, exp_succ ? "R7 total pulses" : "R8 total pulses",
                rise_cnt, exp_rise);
            mism = 0;
            for (k = 0; k < sb; k++) begin
                b = pat(k / 8);
                if (rx_bits[k] !== b[7 - (k % 8)]) mism++;
            end
            chk(mism == 0, (errat >= 0) ? "R6 bits before error" : "R4 R5 MSB-first bits", mism, 0);
            chk(bad_hi == 0, "R10 high phase length", bad_hi, 0);
        end
        if (nb == 0) chk(ready_seen == 0, "R5 R11 zero count requests nothing", ready_seen, 0);
        run_act = 1'b0;
        // R9: status holds and idle lines stay at rest
        repeat (3) @(negedge clk);
        chk(!busy_o && (success_o || timeout_o), "R9 status holds", busy_o, 0);
        chk(program_n_o && !cclk_o && !din_o, "R1 idle lines after run", cclk_o, 0);
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(program_n_o && !cclk_o && !din_o, "R1 reset lines", program_n_o, 1);
        chk(!busy_o && !success_o && !timeout_o && !data_ready_o, "R1 reset status", busy_o, 0);

        // R3: init arrival sweep around the poll limit
        for (int d = 0; d <= IMAX + 2; d++) begin
            if (d < 3 || d >= IMAX - 6) run_seq(1, d, d, 9, -1, 0, 0);
        end
        run_seq(1, 2, 1000, 9, -1, 0, 0);

        // R5 R7 R8: done arrival sweep across the whole window
        for (int a = 0; a <= 16 + DMAX + 2; a++) run_seq(2, a, 3, a, -1, 0, 0);

        // R5: zero count
        run_seq(0, 7, 3, 3, -1, 0, 0);
        run_seq(0, 7, 3, DMAX + 1, -1, 0, 0);

        // R11 R10: stalled stream, several byte counts
        for (int nb = 1; nb <= 6; nb++) run_seq(nb, nb * 5, 4, nb * 8 + 3, -1, 1, 0);

        // R6: stream error at several positions
        run_seq(4, 11, 3, 19, 2, 0, 0);
        run_seq(4, 12, 3, 2, 0, 0, 0);
        run_seq(3, 13, 3, 30, 2, 1, 0);

        // R9: start while busy, and start held through completion
        run_seq(3, 21, 3, 26, -1, 0, 1);
        run_seq(2, 22, 3, 18, -1, 0, 2);
        run_seq(2, 23, 3, 40, -1, 0, 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule